// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the read and write addresses for a single DMA channel that runs a two-level transfer loop. A descriptor is loaded through a set of plain configuration pins. Each service request then starts one inner (minor) loop. The minor loop issues one beat per transfer unit until its byte budget is spent. At the end of the minor loop the block stores the advanced addresses as the channel's saved position and counts down the outer (major) loop. When the outer count runs out, the block adds a final adjustment to the source address and returns to idle.

Either address can be held inside an aligned power-of-two window, which turns a buffer into a circular queue. The source size code selects 1, 2, 4 or 8 bytes per beat, or a 32-byte burst. A burst goes out as four 8-byte beats at consecutive 8-byte steps from the unit's base address. The beats leave on a valid/ready stream. A beat is presented with `beat_valid` and is consumed on the first rising edge where `beat_ready` is also high. While `beat_ready` is low, the beat, its addresses and its attributes stay frozen. The consumer may hold `beat_ready` low for any number of cycles. No beat is ever withdrawn.

Top module: `dma_addr_seq`

## Requirements
- R1: During and after reset, `beat_valid`, `minor_done`, `major_done` and `cfg_err` are 0, and `saved_saddr`, `saved_daddr` and `major_left` are 0.
- R2: The latched source size code sets the bytes per beat: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b100 gives 4. Code 3'b101 is a 32-byte unit sent as four 8-byte beats, with the address offsets +0, +8, +16 and +24 from the unit base applied to both addresses. Each accepted beat takes its byte count off the remaining minor count. `beat_ssize` and `beat_dsize` carry the latched codes.
- R3: After the last beat of each unit, each address advances by its own 16-bit offset (`cfg_soff` or `cfg_doff`), sign-extended to 32 bits. The last beat of a unit is every beat for non-burst codes, the fourth beat of a burst, or the final beat of the minor loop.
- R4: A nonzero modulo value m (5 bits) lets only address bits below m change. Bits m and above keep the value they had before the addition, so each address wraps inside an aligned 2^m-byte window. A modulo value of 0 disables wrapping. The source and destination each use their own modulo value.
- R5: A minor byte count of 0 is treated as 2^32 bytes. The loop keeps issuing non-final beats.
- R6: A started minor loop runs to its final beat and cannot be stopped. While the loop runs, `svc_req` and `cfg_load` have no effect. While `beat_ready` is low, the beat and its addresses hold unchanged.
- R7: `beat_last` marks the beat on which the remaining count is at or below the beat width. On the next cycle `minor_done` pulses for one cycle. In that same cycle `saved_saddr` and `saved_daddr` show the advanced addresses and `major_left` has dropped by one. The next request resumes from the saved addresses.
- R8: When `major_left` reaches 0, `cfg_slast` is added to the saved source address and `major_done` pulses together with `minor_done`. The channel then ignores `svc_req` until a new descriptor is loaded.
- R9: A load is refused if either size code is reserved (3'b110 or 3'b111) or the major count is 0. A refused load sets `cfg_err`, and every later `svc_req` produces no beat. The next good load clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Latch the descriptor pins (ignored while a minor loop runs) |
| cfg_saddr | input | 32 | Start source address |
| cfg_daddr | input | 32 | Start destination address |
| cfg_soff | input | 16 | Signed source step per unit |
| cfg_doff | input | 16 | Signed destination step per unit |
| cfg_smod | input | 5 | Source modulo (0 = off) |
| cfg_dmod | input | 5 | Destination modulo (0 = off) |
| cfg_ssize | input | 3 | Source size code |
| cfg_dsize | input | 3 | Destination size code |
| cfg_nbytes | input | 32 | Minor loop byte count (0 = 2^32) |
| cfg_major | input | 16 | Major iteration count |
| cfg_slast | input | 32 | Source adjustment applied when the major count ends |
| svc_req | input | 1 | Service request, starts one minor loop |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | Consumer accepts the beat |
| beat_saddr | output | 32 | Read address of the beat |
| beat_daddr | output | 32 | Write address of the beat |
| beat_ssize | output | 3 | Latched source size code |
| beat_dsize | output | 3 | Latched destination size code |
| beat_last | output | 1 | Final beat of the minor loop |
| minor_done | output | 1 | One-cycle pulse after a minor loop ends |
| major_done | output | 1 | One-cycle pulse when the major count reaches 0 |
| cfg_err | output | 1 | Last load was refused |
| saved_saddr | output | 32 | Saved source position |
| saved_daddr | output | 32 | Saved destination position |
| major_left | output | 16 | Remaining major iterations |

## Verification
The assertions check the following on every cycle:
- A stalled beat stays frozen, and a running loop never drops `beat_valid` before its final beat.
- `minor_done` follows only an accepted final beat, and `major_left` drops by exactly one at that point.
- `major_done` coincides with `minor_done` and a zero count, and no beat appears while `cfg_err` is set.
- Consecutive beats differ only in the bits the modulo window allows.

Only the bench's scenarios can show that the address values themselves are right. That covers:
- the sizes, sign-extended steps, burst sub-offsets and wrap points;
- the end-of-major adjustment;
- the 4 GB interpretation of a zero count;
- that requests and loads issued mid-loop leave the sequence untouched.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ARMED = 2'd1,
    SQ_RUN   = 2'd2
  } sq_state_t;

  localparam int LANES    = 2;
  localparam int LANE_SRC = 0;
  localparam int LANE_DST = 1;

  localparam logic [2:0] SZ_BURST = 3'b101;

  // codes 110 and 111 have no meaning
  function automatic logic size_reserved(input logic [2:0] code);
    return code[2] & code[1];
  endfunction

endpackage

// File: rtl/dma_size_decode.sv
module dma_size_decode (
  input  logic [2:0] code,
  output logic [3:0] unit_bytes,
  output logic       burst
);
  import dma_seq_pkg::*;

  always_comb begin
    unit_bytes = 4'd0;
    burst      = 1'b0;
    case (code)
      3'b000:   unit_bytes = 4'd1;
      3'b001:   unit_bytes = 4'd2;
      3'b010:   unit_bytes = 4'd4;
      3'b011:   unit_bytes = 4'd8;
      3'b100:   unit_bytes = 4'd4;
      SZ_BURST: begin
        unit_bytes = 4'd8;   // per beat, four beats per unit
        burst      = 1'b1;
      end
      default:  unit_bytes = 4'd0;
    endcase
  end
endmodule

// File: rtl/dma_addr_wrap.sv
module dma_addr_wrap #(
  parameter int AW = 32,
  parameter int MW = 5
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [MW-1:0] mod,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] sum;
  logic [AW-1:0] frozen;

  assign sum    = cur + step;
  // bits at and above 'mod' are taken from the address before the add
  assign frozen = (mod == '0) ? '0 : ({AW{1'b1}} << mod);
  assign nxt    = (cur & frozen) | (sum & ~frozen);
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int MW = 5,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_saddr,
  input  logic [AW-1:0] cfg_daddr,
  input  logic [OW-1:0] cfg_soff,
  input  logic [OW-1:0] cfg_doff,
  input  logic [MW-1:0] cfg_smod,
  input  logic [MW-1:0] cfg_dmod,
  input  logic [2:0]    cfg_ssize,
  input  logic [2:0]    cfg_dsize,
  input  logic [AW-1:0] cfg_nbytes,
  input  logic [CW-1:0] cfg_major,
  input  logic [AW-1:0] cfg_slast,
  input  logic          svc_req,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] beat_saddr,
  output logic [AW-1:0] beat_daddr,
  output logic [2:0]    beat_ssize,
  output logic [2:0]    beat_dsize,
  output logic          beat_last,
  output logic          minor_done,
  output logic          major_done,
  output logic          cfg_err,
  output logic [AW-1:0] saved_saddr,
  output logic [AW-1:0] saved_daddr,
  output logic [CW-1:0] major_left
);

  localparam int RW       = AW + 1;   // holds 2^AW for a zero count
  localparam int SUBW     = 2;
  localparam int SUB_LAST = 3;
  localparam int SUB_SH   = 3;        // 8-byte steps inside a burst

  sq_state_t st_q;

  logic [LANES-1:0][AW-1:0] base_q;
  logic [LANES-1:0][AW-1:0] saved_q;
  logic [LANES-1:0][AW-1:0] beat_addr;
  logic [LANES-1:0][AW-1:0] next_base;
  logic [LANES-1:0][OW-1:0] off_q;
  logic [LANES-1:0][MW-1:0] mod_q;
  logic [LANES-1:0][2:0]    size_q;

  logic [RW-1:0]   rem_q;
  logic [SUBW-1:0] sub_q;
  logic [CW-1:0]   major_q;
  logic [CW-1:0]   major_dec;
  logic [AW-1:0]   slast_q;
  logic [AW-1:0]   nbytes_q;
  logic [AW-1:0]   src_end;
  logic            err_q;
  logic            minor_q;
  logic            majdone_q;

  logic [3:0] src_bytes;
  logic       src_burst;
  logic       last_beat;
  logic       unit_end;
  logic       load_bad;

  dma_size_decode u_src_size (
    .code       (size_q[LANE_SRC]),
    .unit_bytes (src_bytes),
    .burst      (src_burst)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [AW-1:0] sub_step;
      logic [AW-1:0] off_ext;

      assign sub_step = src_burst ? AW'({sub_q, {SUB_SH{1'b0}}}) : '0;
      assign off_ext  = {{(AW-OW){off_q[i][OW-1]}}, off_q[i]};

      dma_addr_wrap #(.AW(AW), .MW(MW)) u_beat (
        .cur  (base_q[i]),
        .step (sub_step),
        .mod  (mod_q[i]),
        .nxt  (beat_addr[i])
      );

      dma_addr_wrap #(.AW(AW), .MW(MW)) u_next (
        .cur  (base_q[i]),
        .step (off_ext),
        .mod  (mod_q[i]),
        .nxt  (next_base[i])
      );
    end
  endgenerate

  assign last_beat = rem_q <= RW'(src_bytes);
  assign unit_end  = !src_burst || (sub_q == SUBW'(SUB_LAST)) || last_beat;
  assign major_dec = major_q - CW'(1);
  assign src_end   = next_base[LANE_SRC] + ((major_dec == '0) ? slast_q : '0);
  assign load_bad  = size_reserved(cfg_ssize) | size_reserved(cfg_dsize)
                   | (cfg_major == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      base_q    <= '0;
      saved_q   <= '0;
      off_q     <= '0;
      mod_q     <= '0;
      size_q    <= '0;
      rem_q     <= '0;
      sub_q     <= '0;
      major_q   <= '0;
      slast_q   <= '0;
      nbytes_q  <= '0;
      err_q     <= 1'b0;
      minor_q   <= 1'b0;
      majdone_q <= 1'b0;
    end else begin
      minor_q   <= 1'b0;
      majdone_q <= 1'b0;
      case (st_q)
        SQ_RUN: begin
          if (beat_ready) begin
            rem_q <= rem_q - RW'(src_bytes);
            if (unit_end) begin
              sub_q  <= '0;
              base_q <= next_base;
            end else begin
              sub_q <= sub_q + SUBW'(1);
            end
            if (last_beat) begin
              saved_q[LANE_SRC] <= src_end;
              saved_q[LANE_DST] <= next_base[LANE_DST];
              major_q           <= major_dec;
              minor_q           <= 1'b1;
              majdone_q         <= (major_dec == '0);
              st_q              <= (major_dec == '0) ? SQ_IDLE : SQ_ARMED;
            end
          end
        end
        default: begin
          if (cfg_load) begin
            saved_q[LANE_SRC] <= cfg_saddr;
            saved_q[LANE_DST] <= cfg_daddr;
            off_q[LANE_SRC]   <= cfg_soff;
            off_q[LANE_DST]   <= cfg_doff;
            mod_q[LANE_SRC]   <= cfg_smod;
            mod_q[LANE_DST]   <= cfg_dmod;
            size_q[LANE_SRC]  <= cfg_ssize;
            size_q[LANE_DST]  <= cfg_dsize;
            nbytes_q          <= cfg_nbytes;
            slast_q           <= cfg_slast;
            major_q           <= cfg_major;
            err_q             <= load_bad;
            st_q              <= load_bad ? SQ_IDLE : SQ_ARMED;
          end else if (st_q == SQ_ARMED && svc_req) begin
            base_q <= saved_q;
            rem_q  <= (nbytes_q == '0) ? {1'b1, {AW{1'b0}}} : {1'b0, nbytes_q};
            sub_q  <= '0;
            st_q   <= SQ_RUN;
          end
        end
      endcase
    end
  end

  assign beat_valid  = (st_q == SQ_RUN);
  assign beat_saddr  = beat_addr[LANE_SRC];
  assign beat_daddr  = beat_addr[LANE_DST];
  assign beat_ssize  = size_q[LANE_SRC];
  assign beat_dsize  = size_q[LANE_DST];
  assign beat_last   = beat_valid && last_beat;
  assign minor_done  = minor_q;
  assign major_done  = majdone_q;
  assign cfg_err     = err_q;
  assign saved_saddr = saved_q[LANE_SRC];
  assign saved_daddr = saved_q[LANE_DST];
  assign major_left  = major_q;

endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
  parameter int AW = 32,
  parameter int MW = 5,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_saddr,
  input logic [AW-1:0] beat_daddr,
  input logic          beat_last,
  input logic          minor_done,
  input logic          major_done,
  input logic          cfg_err,
  input logic [CW-1:0] major_left,
  input logic [MW-1:0] smod,
  input logic [MW-1:0] dmod
);
  logic [AW-1:0] hi_s;
  logic [AW-1:0] hi_d;

  assign hi_s = (smod == '0) ? '0 : ({AW{1'b1}} << smod);
  assign hi_d = (dmod == '0) ? '0 : ({AW{1'b1}} << dmod);

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_saddr) && $stable(beat_daddr));

  a_r6_no_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !(beat_ready && beat_last) |=> beat_valid);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    minor_done |-> $past(beat_valid && beat_ready && beat_last));

  a_r7_major_step: assert property (@(posedge clk) disable iff (!rst_n)
    minor_done |-> major_left == ($past(major_left) - CW'(1)));

  a_r8_major_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    major_done |-> minor_done && (major_left == '0) && !beat_valid);

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !beat_valid);

  a_r4_src_window: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last |=> ((beat_saddr ^ $past(beat_saddr)) & hi_s) == '0);

  a_r4_dst_window: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last |=> ((beat_daddr ^ $past(beat_daddr)) & hi_d) == '0);

endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW), .MW(MW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_saddr (beat_saddr),
  .beat_daddr (beat_daddr),
  .beat_last  (beat_last),
  .minor_done (minor_done),
  .major_done (major_done),
  .cfg_err    (cfg_err),
  .major_left (major_left),
  .smod       (mod_q[0]),
  .dmod       (mod_q[1])
);

// File: tb/tb_dma_addr_seq.sv
module tb_dma_addr_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] sa;
    logic [31:0] da;
    logic        last;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [31:0] cfg_saddr = '0, cfg_daddr = '0, cfg_nbytes = '0, cfg_slast = '0;
  logic [15:0] cfg_soff = '0, cfg_doff = '0, cfg_major = '0;
  logic [4:0]  cfg_smod = '0, cfg_dmod = '0;
  logic [2:0]  cfg_ssize = '0, cfg_dsize = '0;
  logic svc_req = 1'b0;
  logic beat_ready = 1'b0;
  logic beat_valid, beat_last, minor_done, major_done, cfg_err;
  logic [31:0] beat_saddr, beat_daddr, saved_saddr, saved_daddr;
  logic [2:0]  beat_ssize, beat_dsize;
  logic [15:0] major_left;

  dma_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_saddr(cfg_saddr), .cfg_daddr(cfg_daddr), .cfg_soff(cfg_soff), .cfg_doff(cfg_doff),
    .cfg_smod(cfg_smod), .cfg_dmod(cfg_dmod), .cfg_ssize(cfg_ssize), .cfg_dsize(cfg_dsize),
    .cfg_nbytes(cfg_nbytes), .cfg_major(cfg_major), .cfg_slast(cfg_slast),
    .svc_req(svc_req), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_saddr(beat_saddr), .beat_daddr(beat_daddr), .beat_ssize(beat_ssize),
    .beat_dsize(beat_dsize), .beat_last(beat_last), .minor_done(minor_done),
    .major_done(major_done), .cfg_err(cfg_err), .saved_saddr(saved_saddr),
    .saved_daddr(saved_daddr), .major_left(major_left)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  string cur_tag = "R1";
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit rdy_tog = 0;

  // reference model state
  beat_t q[$];
  bit m_run = 0, m_armed = 0, m_err = 0, m_minor = 0, m_majp = 0;
  logic [31:0] m_sv_s = '0, m_sv_d = '0, m_nbytes = '0, m_slast = '0;
  logic [15:0] m_soff = '0, m_doff = '0, m_major = '0;
  logic [4:0]  m_smod = '0, m_dmod = '0;
  logic [2:0]  m_ssize = '0, m_dsize = '0;
  logic [31:0] e_s, e_d;
  logic [15:0] e_major;

  function automatic void chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic longint unit_w(logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b011: return 8;
      3'b101: return 8;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] wrapm(logic [31:0] old, logic [31:0] nw, logic [4:0] m);
    logic [31:0] r;
    for (int b = 0; b < 32; b++)
      r[b] = (m == 0 || b < int'(m)) ? nw[b] : old[b];
    return r;
  endfunction

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic void build();
    longint rem, w;
    logic [31:0] bs, bd;
    int sub, n;
    bit burst, stop;
    beat_t b;
    q.delete();
    rem = (m_nbytes == 0) ? 64'sh1_0000_0000 : longint'({32'd0, m_nbytes});
    bs = m_sv_s; bd = m_sv_d; sub = 0; n = 0; stop = 0;
    w = unit_w(m_ssize);
    burst = (m_ssize == 3'b101);
    while (!stop) begin
      b.sa = burst ? wrapm(bs, bs + 32'(sub * 8), m_smod) : bs;
      b.da = burst ? wrapm(bd, bd + 32'(sub * 8), m_dmod) : bd;
      b.last = (rem <= w);
      q.push_back(b);
      n++;
      rem = rem - w;
      if (burst && sub < 3 && !b.last) sub++;
      else begin
        sub = 0;
        bs = wrapm(bs, bs + sx(m_soff), m_smod);
        bd = wrapm(bd, bd + sx(m_doff), m_dmod);
      end
      if (b.last || n >= 64) stop = 1;
    end
    e_major = m_major - 16'd1;
    e_s = bs + ((e_major == 0) ? m_slast : 32'd0);
    e_d = bd;
  endfunction

  task automatic step(input bit do_req, input bit do_load);
    beat_t b;
    bit rdy, was_run;
    @(negedge clk);
    chk("R6", 64'(beat_valid), 64'(m_run));
    if (m_run && q.size() > 0) begin
      chk(cur_tag, 64'(beat_saddr), 64'(q[0].sa));
      chk(cur_tag, 64'(beat_daddr), 64'(q[0].da));
      chk(cur_tag, 64'(beat_last), 64'(q[0].last));
      chk("R2", 64'({beat_ssize, beat_dsize}), 64'({m_ssize, m_dsize}));
    end
    chk("R7", 64'(minor_done), 64'(m_minor));
    chk("R8", 64'(major_done), 64'(m_majp));
    chk("R9", 64'(cfg_err), 64'(m_err));
    chk("R7", 64'({saved_saddr, saved_daddr}), 64'({m_sv_s, m_sv_d}));
    chk("R7", 64'(major_left), 64'(m_major));
    m_minor = 0; m_majp = 0;
    case (rdy_mode)
      0: rdy = 1;
      1: begin rdy_tog = ~rdy_tog; rdy = rdy_tog; end
      default: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; rdy = lfsr[0]; end
    endcase
    beat_ready = rdy;
    was_run = m_run;
    if (m_run && rdy && q.size() > 0) begin
      b = q.pop_front();
      if (b.last) begin
        m_run = 0; m_minor = 1;
        m_sv_s = e_s; m_sv_d = e_d; m_major = e_major;
        m_majp = (e_major == 0); m_armed = (e_major != 0);
      end
    end
    svc_req = do_req;
    cfg_load = do_load;
    if (do_load && !was_run) begin
      m_err = (cfg_ssize[2] & cfg_ssize[1]) | (cfg_dsize[2] & cfg_dsize[1]) | (cfg_major == 0);
      m_armed = !m_err;
      m_sv_s = cfg_saddr; m_sv_d = cfg_daddr; m_soff = cfg_soff; m_doff = cfg_doff;
      m_smod = cfg_smod; m_dmod = cfg_dmod; m_ssize = cfg_ssize; m_dsize = cfg_dsize;
      m_nbytes = cfg_nbytes; m_slast = cfg_slast; m_major = cfg_major;
    end else if (do_req && !was_run && m_armed) begin
      build();
      m_run = 1;
    end
  endtask

  task automatic setcfg(logic [31:0] sa, logic [31:0] da, logic [15:0] so, logic [15:0] dof,
                        logic [4:0] sm, logic [4:0] dm, logic [2:0] ss, logic [2:0] ds,
                        logic [31:0] nb, logic [15:0] mj, logic [31:0] sl);
    cfg_saddr = sa; cfg_daddr = da; cfg_soff = so; cfg_doff = dof; cfg_smod = sm; cfg_dmod = dm;
    cfg_ssize = ss; cfg_dsize = ds; cfg_nbytes = nb; cfg_major = mj; cfg_slast = sl;
  endtask

  task automatic drain();
    int guard = 0;
    while ((m_run || m_minor) && guard < 2000) begin
      step(0, 0);
      guard++;
    end
    step(0, 0);
  endtask

  task automatic do_reset_check();
    @(negedge clk);
    rst_n = 0; beat_ready = 0; svc_req = 0; cfg_load = 0;
    q.delete();
    m_run = 0; m_armed = 0; m_err = 0; m_minor = 0; m_majp = 0;
    m_sv_s = '0; m_sv_d = '0; m_major = '0; m_ssize = '0; m_dsize = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", 64'({beat_valid, minor_done, major_done, cfg_err}), 64'(0));
    chk("R1", 64'({saved_saddr, saved_daddr}), 64'(0));
    chk("R1", 64'(major_left), 64'(0));
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset_check();

    // two minor loops, 32-bit units, end adjustment back to start
    cur_tag = "R3"; rdy_mode = 0;
    setcfg(32'h2000_0000, 32'h3000_0100, 16'd4, 16'd4, 5'd0, 5'd0, 3'b010, 3'b010,
           32'd16, 16'd2, 32'hFFFF_FFE0);
    step(0, 1);
    step(1, 0); drain();
    step(1, 0); drain();
    cur_tag = "R8";
    step(1, 0); step(0, 0); step(0, 0);   // channel done: request ignored

    // modulo windows with stalls; request and load mid-loop are ignored
    cur_tag = "R4"; rdy_mode = 2;
    setcfg(32'h1000_0030, 32'h4000_0004, 16'd8, 16'hFFFE, 5'd6, 5'd4, 3'b011, 3'b001,
           32'd64, 16'd1, 32'd0);
    step(0, 1);
    step(1, 0);
    step(0, 0);
    setcfg(32'h0BAD_0000, 32'h0BAD_0000, 16'd1, 16'd1, 5'd0, 5'd0, 3'b000, 3'b000,
           32'd1, 16'd9, 32'd0);
    cur_tag = "R6";
    step(1, 1);
    step(1, 0);
    cur_tag = "R4";
    drain();

    // burst unit ending inside the second burst
    cur_tag = "R2"; rdy_mode = 1;
    setcfg(32'h5000_0000, 32'h6000_0000, 16'd32, 16'd32, 5'd0, 5'd0, 3'b101, 3'b011,
           32'd40, 16'd1, 32'd0);
    step(0, 1); step(1, 0); drain();

    // byte units with negative step
    cur_tag = "R3"; rdy_mode = 0;
    setcfg(32'h7000_0003, 32'h7100_0000, 16'hFFFF, 16'd1, 5'd0, 5'd0, 3'b000, 3'b000,
           32'd3, 16'd1, 32'd0);
    step(0, 1); step(1, 0); drain();

    // 16-bit units, count not a multiple of the width
    cur_tag = "R2";
    setcfg(32'h7200_0000, 32'h7300_0000, 16'd2, 16'd2, 5'd0, 5'd0, 3'b001, 3'b001,
           32'd5, 16'd1, 32'd0);
    step(0, 1); step(1, 0); drain();

    // alternate 32-bit code
    setcfg(32'h7400_0000, 32'h7500_0000, 16'd4, 16'd4, 5'd0, 5'd0, 3'b100, 3'b100,
           32'd8, 16'd1, 32'd0);
    step(0, 1); step(1, 0); drain();

    // refused descriptors
    cur_tag = "R9";
    setcfg(32'h8000_0000, 32'h8100_0000, 16'd4, 16'd4, 5'd0, 5'd0, 3'b110, 3'b010,
           32'd8, 16'd1, 32'd0);
    step(0, 1); step(1, 0); step(0, 0); step(0, 0);
    cfg_ssize = 3'b010; cfg_dsize = 3'b111;
    step(0, 1); step(1, 0); step(0, 0);
    cfg_dsize = 3'b010; cfg_major = 16'd0;
    step(0, 1); step(1, 0); step(0, 0);
    cfg_major = 16'd1;
    step(0, 1); step(1, 0); drain();

    // zero minor count means 4 GB: no final beat appears
    cur_tag = "R5"; rdy_mode = 2;
    setcfg(32'h9000_0000, 32'h9100_0000, 16'd8, 16'd8, 5'd0, 5'd0, 3'b011, 3'b011,
           32'd0, 16'd1, 32'd0);
    step(0, 1); step(1, 0);
    for (int k = 0; k < 20; k++) step(0, 0);
    do_reset_check();
    step(0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule